// File: doc/BRIEF.md
# Banked CPU Data-Space Decoder

This block sits between an 8-bit CPU's 64 KB external data space and the targets that share that space. Reads and writes to the same window reach different targets. A CPU read normally fetches from a graphics ROM split into eight 64 KB banks. A small port latch, which the CPU writes and reads back over its own port strobe, picks the bank. A few read offsets near the top of the window are diverted: one returns the player input port, and six return a status byte. The meaning of that status byte is not known, so the block supplies a pseudo-random value from an internal LFSR that steps on each such read. A CPU write is steered by address range to visible video memory, off-screen video memory, palette memory or the control register file.

The decoder makes one-hot chip selects and the read-data multiplexer in the same cycle as the access. The ROM and the input port are treated as combinational sources. Only the port latch and the LFSR hold state.

Top module: `dspace_decoder`

## Requirements
- R1: After a synchronous active-low reset, the port latch output `port_q` reads 0x00 and the ROM bank is 0.
- R2: A cycle with `port_wr` high loads `cpu_wdata` into the port latch, and `port_q` shows that value from the next cycle until the next port write.
- R3: A read (`cpu_rd` high, `cpu_wr` low) at an offset that is not diverted asserts only `rom_re`. It drives `rom_addr = {port_q[2:0], cpu_addr}`, which is bank*0x10000 + offset, and returns `rom_rdata` on `rd_data`.
- R4: A read at offset 0xFFFE asserts only `inp_re` and returns `player_in` on `rd_data`.
- R5: A read at 0xFFF3, 0xFFF4, 0xFFF8, 0xFFFB, 0xFFFC or 0xFFFD asserts only `stat_re` and returns bits 7:0 of a 16-bit LFSR. The LFSR resets to 0xACE1. It shifts left by one after each such read only, and the new bit 0 is the XOR of old bits 15, 13, 12 and 10.
- R6: A write (`cpu_wr` high, `cpu_rd` low) below 0xD800 asserts only `vis_we`.
- R7: A write from 0xD800 to 0xFDFF inclusive asserts only `hid_we`.
- R8: A write from 0xFE00 to 0xFFDF inclusive asserts only `pal_we`.
- R9: A write from 0xFFE0 to 0xFFFF inclusive asserts only `reg_we`, and this includes the offsets that are diverted on reads.
- R10: At most one select is high in any cycle, and exactly one is high for a valid access. A cycle with neither strobe, or with both strobes, selects nothing, returns 0x00 on `rd_data` and does not step the LFSR.
- R11: Port latch bits 7:3 have no effect on the ROM bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU data-space offset |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data (also feeds the port latch) |
| port_wr | input | 1 | Port latch write strobe |
| port_q | output | 8 | Port latch contents, read back by the CPU |
| rom_rdata | input | 8 | Data from the banked graphics ROM |
| player_in | input | 8 | Player input port |
| rom_addr | output | 19 | Banked ROM byte address |
| rom_re | output | 1 | ROM read select |
| inp_re | output | 1 | Input port read select |
| stat_re | output | 1 | Status read select |
| vis_we | output | 1 | Visible video memory write select |
| hid_we | output | 1 | Off-screen video memory write select |
| pal_we | output | 1 | Palette memory write select |
| reg_we | output | 1 | Control register write select |
| rd_data | output | 8 | Read data to the CPU |

## Verification
The assertions check three things on every cycle: the selects are one-hot, the port latch returns the value last written, and the LFSR moves only on status reads. They also check that the ROM address and the input-port data reach the outputs as given. Only the bench's scenarios can show the exact range edges, such as 0xD7FF against 0xD800 or 0xFFDF against 0xFFE0, and which offsets are diverted. The same holds for the LFSR sequence values and for bank selection across all eight banks with the upper latch bits set. For these the bench compares against its own cycle-by-cycle model.

// File: rtl/dsd_pkg.sv
// Package: shared widths, address boundaries and the select vector type
// for the banked data-space decoder.
package dsd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int BANK_W = 3;
    localparam int LFSR_W = 16;

    localparam logic [ADDR_W-1:0] HID_BASE = 16'hD800;
    localparam logic [ADDR_W-1:0] PAL_BASE = 16'hFE00;
    localparam logic [ADDR_W-1:0] REG_BASE = 16'hFFE0;
    localparam logic [ADDR_W-1:0] INP_OFFS = 16'hFFFE;

    localparam int N_STAT = 6;
    localparam logic [N_STAT-1:0][ADDR_W-1:0] STAT_OFFS =
        {16'hFFF3, 16'hFFF4, 16'hFFF8, 16'hFFFB, 16'hFFFC, 16'hFFFD};

    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

    typedef struct packed {
        logic rom;
        logic inp;
        logic stat;
        logic vis;
        logic hid;
        logic pal;
        logic regf;
    } dsd_sel_t;

    // True when an offset is one of the diverted status locations.
    function automatic logic is_stat(input logic [ADDR_W-1:0] a);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_STAT; i++)
            if (a == STAT_OFFS[i]) hit = 1'b1;
        return hit;
    endfunction
endpackage

// File: rtl/dsd_port_latch.sv
// Port latch: holds the CPU-written port byte whose low bits pick the ROM bank.
// Assumes a synchronous active-low reset and a single-cycle write strobe.
module dsd_port_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load on write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= wdata;
    end

    // R2
    latch_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> q == $past(wdata));
    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(q));
endmodule

// File: rtl/dsd_lfsr.sv
// Status source: Fibonacci LFSR that steps once per enabled cycle.
// Assumes TAPS describe a maximal-length polynomial for width W.
module dsd_lfsr #(
    parameter int           W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    logic fb;

    // Feedback bit is the parity of the tapped bits.
    always_comb fb = ^(state & TAPS);

    // Shift left on step, reseed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= SEED;
        else if (step) state <= {state[W-2:0], fb};
    end

    // R5
    lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> state[W-1:1] == $past(state[W-2:0]));
    // R10
    lfsr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state));
    // R5
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/dsd_addr_decode.sv
// Address decoder: turns a strobe pair and an offset into one-hot selects.
// Reads and writes with the same offset reach different targets.
// Assumes both strobes together is an invalid access and selects nothing.
module dsd_addr_decode
    import dsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output dsd_sel_t          sel
);
    logic rd_ok, wr_ok, hit_inp, hit_stat;

    // Classify the strobes and the diverted read offsets.
    always_comb begin
        rd_ok    = rd && !wr;
        wr_ok    = wr && !rd;
        hit_inp  = addr == INP_OFFS;
        hit_stat = is_stat(addr);
    end

    // Build the select vector from the strobe kind and the address range.
    always_comb begin
        sel      = '0;
        sel.rom  = rd_ok && !hit_inp && !hit_stat;
        sel.inp  = rd_ok && hit_inp;
        sel.stat = rd_ok && hit_stat;
        sel.vis  = wr_ok && (addr < HID_BASE);
        sel.hid  = wr_ok && (addr >= HID_BASE) && (addr < PAL_BASE);
        sel.pal  = wr_ok && (addr >= PAL_BASE) && (addr < REG_BASE);
        sel.regf = wr_ok && (addr >= REG_BASE);
    end

    // R10
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    // R10
    sel_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd ^ wr) |-> $countones(sel) == 1);
    // R9
    reg_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && addr[15:5] == 11'h7FF) |-> sel.regf);
endmodule

// File: rtl/dspace_decoder.sv
// Top: banked CPU data-space decoder. Joins the port latch, the status LFSR
// and the address decoder, forms the banked ROM address and muxes read data.
// Assumes the ROM and the input port return data in the cycle of the access.
module dspace_decoder
    import dsd_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  logic                     port_wr,
    output logic [DATA_W-1:0]        port_q,
    input  logic [DATA_W-1:0]        rom_rdata,
    input  logic [DATA_W-1:0]        player_in,
    output logic [BANK_W+ADDR_W-1:0] rom_addr,
    output logic                     rom_re,
    output logic                     inp_re,
    output logic                     stat_re,
    output logic                     vis_we,
    output logic                     hid_we,
    output logic                     pal_we,
    output logic                     reg_we,
    output logic [DATA_W-1:0]        rd_data
);
    dsd_sel_t          sel;
    logic [LFSR_W-1:0] lfsr_q;

    dsd_port_latch #(.W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr(port_wr), .wdata(cpu_wdata), .q(port_q)
    );

    dsd_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(sel.stat), .state(lfsr_q)
    );

    dsd_addr_decode u_dec (
        .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .wr(cpu_wr),
        .addr(cpu_addr), .sel(sel)
    );

    // Bank from the low latch bits, offset passed straight through.
    always_comb rom_addr = {port_q[BANK_W-1:0], cpu_addr};

    // Fan the select vector out to the named target strobes.
    always_comb begin
        rom_re  = sel.rom;
        inp_re  = sel.inp;
        stat_re = sel.stat;
        vis_we  = sel.vis;
        hid_we  = sel.hid;
        pal_we  = sel.pal;
        reg_we  = sel.regf;
    end

    // Read-data multiplexer, zero when nothing is read.
    always_comb begin
        rd_data = '0;
        if (sel.rom)  rd_data = rom_rdata;
        if (sel.inp)  rd_data = player_in;
        if (sel.stat) rd_data = lfsr_q[DATA_W-1:0];
    end

    // R4
    inp_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inp_re |-> rd_data == player_in);
    // R3
    rom_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_re |-> (rom_addr[ADDR_W +: BANK_W] == port_q[BANK_W-1:0] && rd_data == rom_rdata));
    // R10
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> rd_data == '0);
endmodule

// File: tb/dspace_decoder_bench.sv
`timescale 1ns/1ps
module dspace_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, port_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0, player_in = 8'h5A;
    logic [7:0]  port_q, rd_data, rom_rdata;
    logic [18:0] rom_addr;
    logic        rom_re, inp_re, stat_re, vis_we, hid_we, pal_we, reg_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    int m_latch = 0;
    int m_lfsr  = 16'hACE1;

    always #5 clk = ~clk;

    // ROM contents are a function of the full banked address.
    assign rom_rdata = rom_addr[7:0] ^ {rom_addr[18:16], rom_addr[15:11]};

    dspace_decoder u_dspace_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .port_wr(port_wr),
        .port_q(port_q), .rom_rdata(rom_rdata), .player_in(player_in),
        .rom_addr(rom_addr), .rom_re(rom_re), .inp_re(inp_re),
        .stat_re(stat_re), .vis_we(vis_we), .hid_we(hid_we),
        .pal_we(pal_we), .reg_we(reg_we), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic bit m_is_stat(input int a);
        return a == 'hFFF3 || a == 'hFFF4 || a == 'hFFF8 ||
               a == 'hFFFB || a == 'hFFFC || a == 'hFFFD;
    endfunction

    // Model update on each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_latch = 0;
            m_lfsr  = 'hACE1;
        end else begin
            if (cpu_rd && !cpu_wr && m_is_stat(cpu_addr)) begin
                int fb;
                fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
                m_lfsr = ((m_lfsr << 1) | fb) & 'hFFFF;
            end
            if (port_wr) m_latch = cpu_wdata;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int a, sel, exp_sel, exp_rd;
            string tag;
            a = cpu_addr;
            sel = {rom_re, inp_re, stat_re, vis_we, hid_we, pal_we, reg_we};
            exp_sel = 0; exp_rd = 0; tag = "R10";
            if (cpu_rd && !cpu_wr) begin
                if (a == 'hFFFE) begin
                    exp_sel = 'b0100000; exp_rd = player_in; tag = "R4";
                end else if (m_is_stat(a)) begin
                    exp_sel = 'b0010000; exp_rd = m_lfsr & 'hFF; tag = "R5";
                end else begin
                    int ra;
                    ra = ((m_latch & 7) << 16) | a;
                    exp_sel = 'b1000000; tag = "R3";
                    exp_rd = (ra & 'hFF) ^ ((ra >> 11) & 'hFF);
                    chk("R3 rom_addr", rom_addr, ra);
                end
            end else if (cpu_wr && !cpu_rd) begin
                if (a < 'hD800)      begin exp_sel = 'b0001000; tag = "R6"; end
                else if (a < 'hFE00) begin exp_sel = 'b0000100; tag = "R7"; end
                else if (a < 'hFFE0) begin exp_sel = 'b0000010; tag = "R8"; end
                else                 begin exp_sel = 'b0000001; tag = "R9"; end
            end
            chk({tag, " selects"}, sel, exp_sel);
            chk({tag, " rd_data"}, rd_data, exp_rd);
            chk("R2 port_q", port_q, m_latch);
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        cpu_rd = 0; cpu_wr = 0; port_wr = 0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(posedge clk); #1;
        cpu_addr = a; cpu_rd = 1; cpu_wr = 0; port_wr = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cpu_addr = a; cpu_wdata = d; cpu_rd = 0; cpu_wr = 1; port_wr = 0;
    endtask

    task automatic pwr(input logic [7:0] d);
        @(posedge clk); #1;
        cpu_wdata = d; port_wr = 1; cpu_rd = 0; cpu_wr = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state of the latch and the bank
        chk("R1 port_q after reset", port_q, 0);
        chk("R1 bank after reset", rom_addr[18:16], 0);
        // R3 bank 0 reads
        rd(16'h0000); rd(16'h1234); rd(16'hFFFF); rd(16'hFFF0);
        // R2, R3: each bank in turn
        for (int b = 0; b < 8; b++) begin
            pwr(8'(b)); idle(); rd(16'hA5C3); rd(16'hFFF5);
        end
        // R11: upper latch bits ignored for the bank
        pwr(8'hF9); idle(); rd(16'h4321);
        @(negedge clk);
        chk("R11 bank with upper bits set", rom_addr[18:16], 1);
        // R4: input port with two values
        rd(16'hFFFE); player_in = 8'hC3; rd(16'hFFFE);
        // R5: all status offsets, some repeated, sequence checked by model
        rd(16'hFFF3); rd(16'hFFF4); rd(16'hFFF8); rd(16'hFFFB);
        rd(16'hFFFC); rd(16'hFFFD); idle(); rd(16'hFFF3); rd(16'hFFF3);
        // R6..R9: write range edges, including diverted read offsets
        wr(16'h0000, 8'h11); wr(16'hD7FF, 8'h22); wr(16'hD800, 8'h33);
        wr(16'hFDFF, 8'h44); wr(16'hFE00, 8'h55); wr(16'hFFDF, 8'h66);
        wr(16'hFFE0, 8'h77); wr(16'hFFF3, 8'h88); wr(16'hFFFE, 8'h99);
        wr(16'hFFFF, 8'hAA);
        // R10: both strobes, then a status read to show the LFSR did not step
        @(posedge clk); #1;
        cpu_addr = 16'hFFF4; cpu_rd = 1; cpu_wr = 1;
        rd(16'hFFF4);
        idle();
        // R2: latch holds through CPU traffic
        pwr(8'h3C); wr(16'h0100, 8'h00); rd(16'h0100); idle();
        // R1: reset mid-run clears the latch and reseeds
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk("R1 port_q after second reset", port_q, 0);
        rd(16'hFFFB);
        idle(); idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule